// File: doc/BRIEF.md
# ADC Compare Window Detector

This block sits beside an analog-to-digital converter and inspects every conversion result as it is delivered. Each result arrives with a valid strobe, its 12-bit value and the number of the channel that produced it. When the result falls into the programmed region, the block raises a sticky event flag. The region is set by a low and a high threshold and one of four comparison modes: below the low threshold, above the high threshold, inside the window, or outside it.

Software-facing control arrives as single-cycle write strobes. Both thresholds are loaded together from one configuration word. A channel-select write either narrows the check to one channel or opens it to every channel. The mode field is loaded as a whole. The event flag is cleared by a status-read strobe. It is gated by a mask bit that has separate enable and disable strobes, and the gated result drives a registered interrupt line.

Top module: `cmp_window_det`

## Requirements
- R1: After a synchronous reset, the event flag, the mask and the interrupt are 0. The configuration is: both thresholds 0, mode 0, single-channel check on channel 0. A result of 0 on channel 0 then sets no flag.
- R2: A threshold write loads both thresholds in the same cycle from one word. The low threshold comes from bits [11:0] and the high threshold from bits [23:12].
- R3: Mode 0 flags a result strictly below the low threshold. Mode 1 flags a result strictly above the high threshold. A result equal to the threshold in use does not flag.
- R4: Mode 2 flags a result with low <= result <= high. Both bounds are included.
- R5: Mode 3 flags a result with result < low or result > high.
- R6: A channel-select write with a 5-bit value below 16 selects that channel and clears the all-channels state. A value of 16 or more sets the all-channels state.
- R7: While the all-channels state is clear, a result from any channel other than the selected one never sets the flag. While it is set, a matching result from any channel sets the flag.
- R8: The flag is set in the clock edge that takes a matching valid result. It stays set until a status-read strobe clears it. If a status read and a matching result fall in the same cycle, the flag stays 1.
- R9: The mask enable strobe sets the mask and the disable strobe clears it. If both are given in the same cycle, disable wins. The interrupt output equals flag AND mask, and it is registered in the same edge as the flag.
- R10: A mode write replaces the whole 2-bit mode. For example, writing 2 after 1 gives mode 2, not the OR of the two values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Conversion result strobe |
| res_data | input | 12 | Conversion result |
| res_chan | input | 4 | Channel number of the result |
| win_we | input | 1 | Threshold word write strobe |
| win_word | input | 24 | High threshold [23:12], low threshold [11:0] |
| mode_we | input | 1 | Mode write strobe |
| mode_in | input | 2 | Mode: 0 below, 1 above, 2 inside, 3 outside |
| sel_we | input | 1 | Channel-select write strobe |
| sel_in | input | 5 | Channel number; 16 or more means all channels |
| int_en | input | 1 | Mask enable strobe |
| int_dis | input | 1 | Mask disable strobe |
| status_rd | input | 1 | Status read strobe; clears the flag |
| evt_flag | output | 1 | Sticky compare event |
| int_mask | output | 1 | Interrupt mask state |
| irq | output | 1 | Masked interrupt |

## Verification
Two cases can land in the same cycle. The first is a status read arriving together with a matching result: the bench drives both strobes in one cycle while the flag is already set, and expects the flag to stay 1 and to clear only on a later read with no match. The second is the mask enable and disable strobes given together: the bench expects the mask to end at 0 and the interrupt to stay low even while the flag is high.

// File: rtl/cmpw_pkg.sv
package cmpw_pkg;
  typedef enum logic [1:0] {
    CMP_BELOW   = 2'd0,
    CMP_ABOVE   = 2'd1,
    CMP_INSIDE  = 2'd2,
    CMP_OUTSIDE = 2'd3
  } cmp_mode_e;
endpackage

// File: rtl/cmpw_cfg.sv
module cmpw_cfg
  import cmpw_pkg::*;
#(
  parameter int DW   = 12,
  parameter int CH_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_we,
  input  logic [2*DW-1:0]  win_word,
  input  logic             mode_we,
  input  logic [1:0]       mode_in,
  input  logic             sel_we,
  input  logic [CH_W:0]    sel_in,
  output logic [DW-1:0]    thr_lo,
  output logic [DW-1:0]    thr_hi,
  output cmp_mode_e        mode,
  output logic [CH_W-1:0]  sel_chan,
  output logic             sel_all
);
  // top bit of the select word marks a value beyond the channel range
  localparam int ALL_BIT = CH_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_lo   <= '0;
      thr_hi   <= '0;
      mode     <= CMP_BELOW;
      sel_chan <= '0;
      sel_all  <= 1'b0;
    end else begin
      if (win_we) begin
        thr_lo <= win_word[DW-1:0];
        thr_hi <= win_word[2*DW-1:DW];
      end
      if (mode_we) mode <= cmp_mode_e'(mode_in);
      if (sel_we) begin
        if (sel_in[ALL_BIT]) begin
          sel_all <= 1'b1;
        end else begin
          sel_all  <= 1'b0;
          sel_chan <= sel_in[CH_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/cmpw_match.sv
module cmpw_match
  import cmpw_pkg::*;
#(
  parameter int DW   = 12,
  parameter int CH_W = 4
) (
  input  logic            valid,
  input  logic [DW-1:0]   data,
  input  logic [CH_W-1:0] chan,
  input  logic [DW-1:0]   thr_lo,
  input  logic [DW-1:0]   thr_hi,
  input  cmp_mode_e       mode,
  input  logic [CH_W-1:0] sel_chan,
  input  logic            sel_all,
  output logic            hit
);
  logic lt_lo, gt_hi, in_win, cond, chan_ok;

  always_comb begin
    lt_lo  = data < thr_lo;
    gt_hi  = data > thr_hi;
    in_win = !lt_lo && !gt_hi;
    unique case (mode)
      CMP_BELOW:   cond = lt_lo;
      CMP_ABOVE:   cond = gt_hi;
      CMP_INSIDE:  cond = in_win;
      CMP_OUTSIDE: cond = lt_lo || gt_hi;
      default:     cond = 1'b0;
    endcase
    chan_ok = sel_all || (chan == sel_chan);
    hit     = valid && chan_ok && cond;
  end
endmodule

// File: rtl/cmpw_event.sv
module cmpw_event (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic status_rd,
  input  logic int_en,
  input  logic int_dis,
  output logic evt_flag,
  output logic int_mask,
  output logic irq
);
  logic flag_n, mask_n;

  always_comb begin
    // a new hit outranks the clearing read
    flag_n = hit ? 1'b1 : (status_rd ? 1'b0 : evt_flag);
    // disable outranks enable
    mask_n = int_dis ? 1'b0 : (int_en ? 1'b1 : int_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_flag <= 1'b0;
      int_mask <= 1'b0;
      irq      <= 1'b0;
    end else begin
      evt_flag <= flag_n;
      int_mask <= mask_n;
      irq      <= flag_n & mask_n;
    end
  end
endmodule

// File: rtl/cmp_window_det.sv
module cmp_window_det
  import cmpw_pkg::*;
#(
  parameter int DW   = 12,
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            res_valid,
  input  logic [DW-1:0]   res_data,
  input  logic [CH_W-1:0] res_chan,
  input  logic            win_we,
  input  logic [2*DW-1:0] win_word,
  input  logic            mode_we,
  input  logic [1:0]      mode_in,
  input  logic            sel_we,
  input  logic [CH_W:0]   sel_in,
  input  logic            int_en,
  input  logic            int_dis,
  input  logic            status_rd,
  output logic            evt_flag,
  output logic            int_mask,
  output logic            irq
);
  logic [DW-1:0]   cfg_lo, cfg_hi;
  cmp_mode_e       cfg_mode;
  logic [CH_W-1:0] cfg_sel;
  logic            cfg_all;
  logic            cmp_hit;

  cmpw_cfg #(.DW(DW), .CH_W(CH_W)) u_cfg (
    .clk(clk), .rst(rst),
    .win_we(win_we), .win_word(win_word),
    .mode_we(mode_we), .mode_in(mode_in),
    .sel_we(sel_we), .sel_in(sel_in),
    .thr_lo(cfg_lo), .thr_hi(cfg_hi), .mode(cfg_mode),
    .sel_chan(cfg_sel), .sel_all(cfg_all)
  );

  cmpw_match #(.DW(DW), .CH_W(CH_W)) u_match (
    .valid(res_valid), .data(res_data), .chan(res_chan),
    .thr_lo(cfg_lo), .thr_hi(cfg_hi), .mode(cfg_mode),
    .sel_chan(cfg_sel), .sel_all(cfg_all), .hit(cmp_hit)
  );

  cmpw_event u_evt (
    .clk(clk), .rst(rst), .hit(cmp_hit), .status_rd(status_rd),
    .int_en(int_en), .int_dis(int_dis),
    .evt_flag(evt_flag), .int_mask(int_mask), .irq(irq)
  );
endmodule

// File: rtl/cmpw_checker.sv
module cmpw_checker #(
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            res_valid,
  input logic [CH_W-1:0] res_chan,
  input logic            status_rd,
  input logic            int_en,
  input logic            int_dis,
  input logic            evt_flag,
  input logic            int_mask,
  input logic            irq,
  input logic [CH_W-1:0] cfg_sel,
  input logic            cfg_all
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!evt_flag && !int_mask && !irq)); // R1

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (evt_flag && !status_rd) |=> evt_flag); // R8

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !res_valid) |=> !evt_flag); // R8

  AST_SET_NEEDS_RESULT: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_flag) |-> $past(res_valid)); // R8

  AST_UNSELECTED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !cfg_all && res_chan != cfg_sel && !evt_flag) |=> !evt_flag); // R7

  AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (rst)
    int_dis |=> (!int_mask && !irq)); // R9

  AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (rst)
    (int_en && !int_dis) |=> int_mask); // R9

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> (evt_flag && int_mask)); // R9
endmodule

bind cmp_window_det cmpw_checker #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst(rst), .res_valid(res_valid), .res_chan(res_chan),
  .status_rd(status_rd), .int_en(int_en), .int_dis(int_dis),
  .evt_flag(evt_flag), .int_mask(int_mask), .irq(irq),
  .cfg_sel(cfg_sel), .cfg_all(cfg_all)
);

// File: tb/cmp_window_det_tb.sv
module cmp_window_det_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 12;
  localparam int CH_W = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            res_valid = 1'b0;
  logic [DW-1:0]   res_data = '0;
  logic [CH_W-1:0] res_chan = '0;
  logic            win_we = 1'b0;
  logic [2*DW-1:0] win_word = '0;
  logic            mode_we = 1'b0;
  logic [1:0]      mode_in = '0;
  logic            sel_we = 1'b0;
  logic [CH_W:0]   sel_in = '0;
  logic            int_en = 1'b0;
  logic            int_dis = 1'b0;
  logic            status_rd = 1'b0;
  logic            evt_flag, int_mask, irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [2:0] exp_q[$];
  string      req_q[$];

  // reference model state
  logic [DW-1:0]   m_lo = '0, m_hi = '0;
  logic [1:0]      m_mode = '0;
  logic [CH_W-1:0] m_sel = '0;
  logic            m_all = 1'b0, m_flag = 1'b0, m_mask = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_window_det #(.DW(DW), .CH_W(CH_W)) u_dut (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .res_chan(res_chan), .win_we(win_we), .win_word(win_word),
    .mode_we(mode_we), .mode_in(mode_in), .sel_we(sel_we), .sel_in(sel_in),
    .int_en(int_en), .int_dis(int_dis), .status_rd(status_rd),
    .evt_flag(evt_flag), .int_mask(int_mask), .irq(irq)
  );

  // one cycle of stimulus; expected outputs after the next edge are queued
  task automatic step(input bit v, input int d, input int ch,
                      input bit wwe, input int lo, input int hi,
                      input bit mwe, input int md,
                      input bit swe, input int sl,
                      input bit ien, input bit idis, input bit rd,
                      input string req);
    logic cond, hit, fn, mn;
    @(negedge clk);
    res_valid = v; res_data = DW'(d); res_chan = CH_W'(ch);
    win_we = wwe; win_word = {DW'(hi), DW'(lo)};
    mode_we = mwe; mode_in = 2'(md);
    sel_we = swe; sel_in = (CH_W+1)'(sl);
    int_en = ien; int_dis = idis; status_rd = rd;
    case (m_mode)
      2'd0: cond = res_data < m_lo;
      2'd1: cond = res_data > m_hi;
      2'd2: cond = (res_data >= m_lo) && (res_data <= m_hi);
      default: cond = (res_data < m_lo) || (res_data > m_hi);
    endcase
    hit = v && (m_all || res_chan == m_sel) && cond;
    fn = hit ? 1'b1 : (rd ? 1'b0 : m_flag);
    mn = idis ? 1'b0 : (ien ? 1'b1 : m_mask);
    m_flag = fn; m_mask = mn;
    if (wwe) begin m_lo = DW'(lo); m_hi = DW'(hi); end
    if (mwe) m_mode = 2'(md);
    if (swe) begin
      if (sl >= (1 << CH_W)) m_all = 1'b1;
      else begin m_all = 1'b0; m_sel = CH_W'(sl); end
    end
    exp_q.push_back({fn, mn, fn & mn});
    req_q.push_back(req);
  endtask

  task automatic res(input int d, input int ch, input string req);
    step(1, d, ch, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic rd_clr(input string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, req);
  endtask
  task automatic set_mode(input int md, input string req);
    step(0, 0, 0, 0, 0, 0, 1, md, 0, 0, 0, 0, 0, req);
  endtask
  task automatic set_win(input int lo, input int hi, input string req);
    step(0, 0, 0, 1, lo, hi, 0, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic set_sel(input int sl, input string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, sl, 0, 0, 0, req);
  endtask

  // monitor: compares one queued item per cycle, after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      n_vec++;
      if ({evt_flag, int_mask, irq} !== e) begin
        n_bad++;
        $display("FAIL %s: flag/mask/irq actual %b expected %b", r,
                 {evt_flag, int_mask, irq}, e);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_vec++;
    if ({evt_flag, int_mask, irq} !== 3'b000) begin
      n_bad++;
      $display("FAIL R1: reset outputs actual %b expected 000", {evt_flag, int_mask, irq});
    end
    res(0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R9");
    set_win(100, 200, "R2");
    // below mode
    res(99, 0, "R3");  rd_clr("R8");
    res(100, 0, "R3");
    // above mode, then whole-field replace
    set_mode(1, "R3");
    res(200, 0, "R3"); res(201, 0, "R3"); rd_clr("R8");
    set_mode(2, "R10");
    res(150, 0, "R10"); rd_clr("R8");
    // inside, inclusive bounds
    res(100, 0, "R4"); rd_clr("R8");
    res(200, 0, "R4"); rd_clr("R8");
    res(201, 0, "R4"); res(99, 0, "R4");
    // outside
    set_mode(3, "R5");
    res(99, 0, "R5"); rd_clr("R8");
    res(150, 0, "R5");
    res(201, 0, "R5"); rd_clr("R8");
    // new window word, inside mode
    set_mode(2, "R4");
    set_win(500, 600, "R2");
    res(150, 0, "R2"); res(550, 0, "R2"); rd_clr("R8");
    // channel selection
    set_sel(3, "R6");
    res(550, 0, "R7"); res(550, 7, "R7");
    res(550, 3, "R7"); rd_clr("R8");
    set_sel(20, "R6");
    res(550, 9, "R6"); rd_clr("R8");
    res(550, 15, "R7"); rd_clr("R8");
    set_sel(5, "R6");
    res(550, 3, "R6"); res(550, 5, "R6");
    // sticky flag, then read colliding with a hit
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    step(1, 550, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R8");
    rd_clr("R8");
    // mask collision and gating
    res(550, 5, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R9");
    rd_clr("R9");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule